// File: doc/BRIEF.md
# Synchronous Clock Stop and Power-Down Gate

This block sits between a set of already generated source clocks and the clock outputs of a chip. It turns the outputs on and off according to two active-low control inputs, one for power down and one for stopping the PCI clocks, and reports which of three operating modes is in force. The outputs fall into three groups. Normal PCI outputs stop whenever a PCI stop is requested. Mappable PCI outputs behave either as normal PCI outputs or as free-running ones, chosen per output by a strap-derived configuration input. Fixed and reference outputs keep running in every mode except power down.

All control inputs are asynchronous. They are resynchronized in a control clock domain, turned there into one enable request per output, and each request is synchronized again into the domain of the clock it gates. Each enable is then re-registered on the falling edge of its source clock, so that a gate can open or close only while that clock is low. An output therefore never carries a shortened high pulse. The enable states are fed back into the control domain. The mode status changes only after every gate has reached the state that was requested.

After a power down, and after reset, every output stays low until a configuration-valid pulse arrives from the strap controller while power down is released.

Top module: `clk_stop_gate`

## Requirements
- R1: While `pwrdn_n_i` is 0, the requests for every output are 0, and each output goes low and stays low whatever the other inputs are.
- R2: While `pwrdn_n_i` is 1, the configuration is valid and `pcistp_n_i` is 0, the normal PCI outputs are held low. Fixed outputs and free-running mapped outputs keep toggling.
- R3: While `pwrdn_n_i` is 1, the configuration is valid and `pcistp_n_i` is 1, every output follows its source clock.
- R4: Every output is low while its source clock is low. An enable changes only at a falling source edge, so each output high pulse is a full source high phase.
- R5: Bit i of `map_free_i` set to 1 makes mapped output i free-running: it keeps running in PCI stop. Set to 0, the output stops in PCI stop like a normal PCI output.
- R6: After reset or after `pwrdn_n_i` has been 0, all outputs stay low until `cfg_valid_i` has been seen at 1 while `pwrdn_n_i` is 1. A single such pulse is enough.
- R7: `mode_o` reports 0 for run, 1 for PCI stop and 2 for power down (this includes the configuration wait). It never shows 3. It changes only when the synchronized gate states of all outputs equal the requested states.
- R8: During reset all outputs are low and `mode_o` is 2.
- R9: When all clocks share one source, an input value sampled at control edge k first appears in the output high phase after edge k+5. It reaches `mode_o` after edge k+7, provided the input was held for at least four edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control domain clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in every domain |
| src_pci_clk | input | 1 | Source clock for normal and mapped PCI outputs |
| src_fix_clk | input | 1 | Source clock for fixed/reference outputs |
| pwrdn_n_i | input | 1 | Power-down request, active low, asynchronous |
| pcistp_n_i | input | 1 | PCI stop request, active low, asynchronous |
| cfg_valid_i | input | 1 | Strap configuration valid pulse |
| map_free_i | input | N_MAP | Per mapped output: 1 free-running, 0 normal PCI |
| pci_clk_o | output | N_PCI | Gated normal PCI clocks |
| map_clk_o | output | N_MAP | Gated mappable PCI clocks |
| fix_clk_o | output | N_FIX | Gated fixed/reference clocks |
| mode_o | output | 2 | Effective mode: 0 run, 1 PCI stop, 2 power down |

## Verification
The assertions check four things on every cycle. A PCI-domain enable never changes during a source high phase. `mode_o` moves only when the fed-back gate states match the requests. A normal PCI request is never raised while the fixed group is off. No request is raised during the configuration wait. Only the bench scenarios can show the observable results. These are the exact cycle in which each output starts or stops after an input change, the per-output effect of the mapping bits in PCI stop, the configuration-valid wait after power down, and the mode lag when the stop input toggles faster than the feedback loop.

// File: rtl/clk_stop_gate_pkg.sv
// Shared types for the clock stop/power-down gate.
package clk_stop_gate_pkg;
    typedef enum logic [1:0] {
        GM_RUN  = 2'd0,
        GM_STOP = 2'd1,
        GM_DOWN = 2'd2
    } gmode_e;
endpackage

// File: rtl/clk_stop_gate_sync.sv
// Two-flop synchronizer for a W-bit vector.
// Assumes: bits are independent levels; rst_n held for several clk cycles.
module clk_stop_gate_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    // Two-stage capture of the asynchronous vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/clk_stop_gate_cell.sv
// Glitch-free gate for one output clock.
// Synchronizes the enable request into the source clock domain and
// re-registers it on the falling edge, so the AND gate opens or closes
// only while src_clk is low.
// Assumes: req is quasi-static relative to src_clk.
module clk_stop_gate_cell (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    output logic clk_o,
    output logic en_o
);
    logic req_s;
    logic en_q;

    clk_stop_gate_sync #(.W(1), .RST_VAL(1'b0)) u_sync (
        .clk   (src_clk),
        .rst_n (rst_n),
        .d     (req),
        .q     (req_s)
    );

    // Enable update on the falling edge: the clock is low afterwards.
    always_ff @(negedge src_clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= req_s;
    end

    assign clk_o = src_clk & en_q;
    assign en_o  = en_q;
endmodule

// File: rtl/clk_stop_gate_ctrl.sv
// Control-domain logic: input synchronization, configuration wait,
// per-output enable requests and effective-mode tracking.
// Output index order: normal PCI, then mapped, then fixed.
// Assumes: map_free_i only changes while all outputs are off.
module clk_stop_gate_ctrl
    import clk_stop_gate_pkg::*;
#(
    parameter int N_PCI = 2,
    parameter int N_MAP = 2,
    parameter int N_FIX = 3,
    localparam int N_OUT = N_PCI + N_MAP + N_FIX
) (
    input  logic             ctl_clk,
    input  logic             rst_n,
    input  logic             pwrdn_n_i,
    input  logic             pcistp_n_i,
    input  logic             cfg_valid_i,
    input  logic [N_MAP-1:0] map_free_i,
    input  logic [N_OUT-1:0] fb_vec,
    output logic [N_OUT-1:0] req_vec,
    output logic             held_o,
    output logic [1:0]       mode_o
);
    logic [2:0]       in_s;
    logic             pwr_s, stp_s, cfg_s;
    logic             hold_q, hold_next, pwr_on;
    logic             pwr_q, stp_q;
    logic [N_OUT-1:0] stop_class;
    logic [N_OUT-1:0] req_next, req_q;
    gmode_e           mode_q;

    clk_stop_gate_sync #(.W(3), .RST_VAL(3'b000)) u_in (
        .clk   (ctl_clk),
        .rst_n (rst_n),
        .d     ({pwrdn_n_i, pcistp_n_i, cfg_valid_i}),
        .q     (in_s)
    );
    assign {pwr_s, stp_s, cfg_s} = in_s;

    // Which outputs obey the PCI stop request.
    for (genvar i = 0; i < N_OUT; i++) begin : g_class
        if (i < N_PCI) begin : g_pci
            assign stop_class[i] = 1'b1;
        end else if (i < N_PCI + N_MAP) begin : g_map
            assign stop_class[i] = ~map_free_i[i - N_PCI];
        end else begin : g_fix
            assign stop_class[i] = 1'b0;
        end
    end

    // Next configuration-wait state and enable requests.
    always_comb begin
        if (!pwr_s)     hold_next = 1'b1;
        else if (cfg_s) hold_next = 1'b0;
        else            hold_next = hold_q;
        pwr_on   = pwr_s & ~hold_next;
        req_next = {N_OUT{pwr_on}} & (~stop_class | {N_OUT{stp_s}});
    end

    // Register requests and the qualifiers behind them.
    always_ff @(posedge ctl_clk) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
            req_q  <= '0;
            pwr_q  <= 1'b0;
            stp_q  <= 1'b0;
        end else begin
            hold_q <= hold_next;
            req_q  <= req_next;
            pwr_q  <= pwr_on;
            stp_q  <= stp_s;
        end
    end

    // Mode follows requests only once every gate has acknowledged them.
    always_ff @(posedge ctl_clk) begin
        if (!rst_n) begin
            mode_q <= GM_DOWN;
        end else if (fb_vec == req_q) begin
            if (!pwr_q)      mode_q <= GM_DOWN;
            else if (!stp_q) mode_q <= GM_STOP;
            else             mode_q <= GM_RUN;
        end
    end

    assign req_vec = req_q;
    assign held_o  = hold_q;
    assign mode_o  = mode_q;
endmodule

// File: rtl/clk_stop_gate.sv
// Top: one glitch-free gate per output clock, a control block and a
// feedback synchronizer that lets the mode report trail the real gates.
// Assumes: N_PCI >= 1, N_FIX >= 1; source clocks free-running.
module clk_stop_gate #(
    parameter int N_PCI = 2,
    parameter int N_MAP = 2,
    parameter int N_FIX = 3
) (
    input  logic             ctl_clk,
    input  logic             rst_n,
    input  logic             src_pci_clk,
    input  logic             src_fix_clk,
    input  logic             pwrdn_n_i,
    input  logic             pcistp_n_i,
    input  logic             cfg_valid_i,
    input  logic [N_MAP-1:0] map_free_i,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic [N_MAP-1:0] map_clk_o,
    output logic [N_FIX-1:0] fix_clk_o,
    output logic [1:0]       mode_o
);
    localparam int N_PCIDOM = N_PCI + N_MAP;
    localparam int N_OUT    = N_PCIDOM + N_FIX;

    logic [N_OUT-1:0] req_vec;
    logic [N_OUT-1:0] en_vec;
    logic [N_OUT-1:0] fb_vec;
    logic [N_OUT-1:0] gclk;
    logic             held;

    clk_stop_gate_ctrl #(.N_PCI(N_PCI), .N_MAP(N_MAP), .N_FIX(N_FIX)) u_ctrl (
        .ctl_clk     (ctl_clk),
        .rst_n       (rst_n),
        .pwrdn_n_i   (pwrdn_n_i),
        .pcistp_n_i  (pcistp_n_i),
        .cfg_valid_i (cfg_valid_i),
        .map_free_i  (map_free_i),
        .fb_vec      (fb_vec),
        .req_vec     (req_vec),
        .held_o      (held),
        .mode_o      (mode_o)
    );

    // One gate per output, wired to the source clock of its group.
    for (genvar i = 0; i < N_OUT; i++) begin : g_gate
        if (i < N_PCIDOM) begin : g_pcidom
            clk_stop_gate_cell u_cell (
                .src_clk (src_pci_clk),
                .rst_n   (rst_n),
                .req     (req_vec[i]),
                .clk_o   (gclk[i]),
                .en_o    (en_vec[i])
            );
        end else begin : g_fixdom
            clk_stop_gate_cell u_cell (
                .src_clk (src_fix_clk),
                .rst_n   (rst_n),
                .req     (req_vec[i]),
                .clk_o   (gclk[i]),
                .en_o    (en_vec[i])
            );
        end
    end

    clk_stop_gate_sync #(.W(N_OUT), .RST_VAL('0)) u_fb (
        .clk   (ctl_clk),
        .rst_n (rst_n),
        .d     (en_vec),
        .q     (fb_vec)
    );

    assign pci_clk_o = gclk[N_PCI-1:0];
    assign map_clk_o = gclk[N_PCI +: N_MAP];
    assign fix_clk_o = gclk[N_PCIDOM +: N_FIX];
endmodule

// File: rtl/clk_stop_gate_chk.sv
// Assertion checker bound into clk_stop_gate; observes requests, gate
// enables, feedback and the reported mode.
module clk_stop_gate_chk #(
    parameter int N_PCI = 2,
    parameter int N_MAP = 2,
    parameter int N_FIX = 3,
    localparam int N_OUT = N_PCI + N_MAP + N_FIX
) (
    input logic             ctl_clk,
    input logic             src_pci_clk,
    input logic             rst_n,
    input logic [1:0]       mode_o,
    input logic [N_OUT-1:0] req_vec,
    input logic [N_OUT-1:0] fb_vec,
    input logic [N_OUT-1:0] en_vec,
    input logic             held
);
    logic [N_PCI+N_MAP-1:0] en_at_rise;

    // Capture PCI-domain enables at each rising source edge.
    always_ff @(posedge src_pci_clk) begin
        if (!rst_n) en_at_rise <= '0;
        else        en_at_rise <= en_vec[N_PCI+N_MAP-1:0];
    end

    // R4: no enable change inside a high phase.
    p_no_runt_r4: assert property (@(negedge src_pci_clk) disable iff (!rst_n)
        en_vec[N_PCI+N_MAP-1:0] == en_at_rise);

    // R7: mode moves only on full acknowledgement.
    p_mode_ack_r7: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        (mode_o != $past(mode_o)) |-> $past(fb_vec == req_vec));

    // R7: encoding 3 never reported.
    p_mode_legal_r7: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        mode_o != 2'd3);

    // R2: a normal PCI request implies the fixed group is requested.
    p_pci_needs_fix_r2: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        !req_vec[N_OUT-1] |-> (req_vec[N_PCI-1:0] == '0));

    // R6: while waiting for configuration nothing is requested.
    p_hold_blocks_r6: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        held |-> (req_vec == '0));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_PCI(N_PCI), .N_MAP(N_MAP), .N_FIX(N_FIX)) u_chk (
    .ctl_clk     (ctl_clk),
    .src_pci_clk (src_pci_clk),
    .rst_n       (rst_n),
    .mode_o      (mode_o),
    .req_vec     (req_vec),
    .fb_vec      (fb_vec),
    .en_vec      (en_vec),
    .held        (held)
);

// File: tb/sim_clk_stop_gate.sv
// Bench: all clocks share one 100 MHz source; a behavioural model keeps a
// history of desired states and predicts every output half-cycle.
module sim_clk_stop_gate;
    localparam int NP = 2, NM = 2, NF = 3, NO = NP + NM + NF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrdn_n = 1'b0, pcistp_n = 1'b1, cfg_valid = 1'b0;
    logic [NM-1:0] map_free = 2'b01;
    logic [NP-1:0] pci_o;
    logic [NM-1:0] map_o;
    logic [NF-1:0] fix_o;
    logic [1:0]    mode;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    clk_stop_gate #(.N_PCI(NP), .N_MAP(NM), .N_FIX(NF)) u0 (
        .ctl_clk(clk), .rst_n(rst_n), .src_pci_clk(clk), .src_fix_clk(clk),
        .pwrdn_n_i(pwrdn_n), .pcistp_n_i(pcistp_n), .cfg_valid_i(cfg_valid),
        .map_free_i(map_free), .pci_clk_o(pci_o), .map_clk_o(map_o),
        .fix_clk_o(fix_o), .mode_o(mode)
    );

    // Desired state codes: 0 run, 1 pci stop, 2 power down, 3 config wait.
    function automatic logic [NO-1:0] vec_of(int code, logic [NM-1:0] mf);
        logic [NO-1:0] v;
        v = '0;
        if (code == 0) v = '1;
        else if (code == 1) begin
            v[NO-1 -: NF] = '1;
            v[NP +: NM]   = mf;
        end
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    logic [NO-1:0] dv [0:7];
    int            dm [0:7];
    bit            hold_m = 1;
    int            exp_mode = 2;

    // Reference model and per-half-cycle comparison.
    initial begin
        for (int i = 0; i < 8; i++) begin dv[i] = '0; dm[i] = 2; end
        forever begin
            int code;
            logic [NO-1:0] v5;
            string tag;
            @(posedge clk);
            for (int i = 7; i > 0; i--) begin dv[i] = dv[i-1]; dm[i] = dm[i-1]; end
            if (!rst_n) begin
                hold_m = 1; code = 2;
            end else begin
                if (!pwrdn_n) hold_m = 1;
                else if (cfg_valid) hold_m = 0;
                code = !pwrdn_n ? 2 : hold_m ? 3 : !pcistp_n ? 1 : 0;
            end
            dm[0] = code;
            dv[0] = vec_of(code, map_free);
            if (!rst_n) exp_mode = 2;
            else if (dv[3] == dv[7]) exp_mode = (dm[3] == 3) ? 2 : dm[3];
            #2;
            v5 = dv[5];
            if (!rst_n) tag = "R8";
            else if (dv[5] != dv[6]) tag = "R9";
            else case (dm[5])
                2: tag = "R1";
                3: tag = "R6";
                1: tag = "R2";
                default: tag = "R3";
            endcase
            check(tag, 32'({fix_o, pci_o}), 32'({v5[NO-1 -: NF], v5[NP-1:0]}));
            check((dm[5] == 1 && tag == "R2") ? "R5" : tag, 32'(map_o), 32'(v5[NP +: NM]));
            check(!rst_n ? "R8" : "R7", 32'(mode), 32'(exp_mode));
            @(negedge clk);
            #2;
            check("R4", 32'({fix_o, map_o, pci_o}), 32'd0);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Stimulus scenarios.
    initial begin
        step(10);
        rst_n = 1'b1;
        pwrdn_n = 1'b1; pcistp_n = 1'b1;
        step(20);                       // R6: waiting for config
        cfg_valid = 1'b1; step(1); cfg_valid = 1'b0;
        step(20);                       // R3: run
        pcistp_n = 1'b0; step(30);      // R2/R5: stop, map 01
        pcistp_n = 1'b1; step(20);
        pwrdn_n = 1'b0; step(20);       // R1: power down
        pcistp_n = 1'b0; cfg_valid = 1'b1; step(5); cfg_valid = 1'b0;
        map_free = 2'b10; step(5);
        pwrdn_n = 1'b1; step(20);       // R6: wait again after power down
        cfg_valid = 1'b1; step(1); cfg_valid = 1'b0;
        step(25);                       // R5: stop with map 10
        for (int k = 0; k < 10; k++) begin  // R7: fast toggling
            pcistp_n = ~pcistp_n; step(3);
        end
        pcistp_n = 1'b1; step(20);
        pwrdn_n = 1'b0; pcistp_n = 1'b0; step(20);  // R1
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule